// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside the data path between a host controller and a NAND flash device and watches every data word that crosses it. Over one whole page it builds a single-error-correcting, double-error-detecting Hamming code. The code is two 16-bit halves: a positional parity and a complemented positional parity. After a program operation the host reads the two halves and stores them as four code bytes next to the page. During a read, the host passes the stored code bytes through the engine directly after the page data. The engine then forms a syndrome and classifies it.

The page length is chosen at run time from four sizes, and the data bus can be 8 or 16 bits wide. Status flags tell the host three things apart: a clean page, a single correctable data error with its exact word and bit, and a flipped bit inside the stored code. Anything else is reported as multiple errors. A page that has been erased and never written reads as all ones. It produces a fixed multiple-error syndrome that software can recognise. Fixing the data in the host buffer and issuing the flash commands are left to the host.

Top module: `nandPageEcc`

## Requirements
- R1: After reset, the mode register (offset 1), the parity register (offset 2), the inverted register (offset 3) and the status register (offset 4) all read zero.
- R2: The mode register holds the page-size select in bits [1:0] (0: 528, 1: 1056, 2: 2112, 3: 4224 bytes) and the wide-bus flag in bit 2 (1 = 16-bit words, so a page has half as many words). It reads back what was written.
- R3: Every data bit has an index equal to word number times bus width plus bit number. Before a check, the parity register reads, in bits [15:0], the XOR of the indices of all set data bits of the page.
- R4: Before a check, the inverted register reads, in bits [15:0], the XOR of the 16-bit complements of the indices of all set data bits.
- R5: A data strobe has no effect while the data-phase enable is low. Strobes after the page and its code words have no effect.
- R6: Writing 1 to bit 0 of the control register (offset 0) clears the accumulators, the word counter and the status. Data strobes received before that write are therefore left out of the code.
- R7: In read flow, the code words follow the page in a fixed order. On an 8-bit bus this is 4 bytes: parity low, parity high, inverted low, inverted high. On a 16-bit bus it is 2 words: parity, then inverted. The check is evaluated once the last code word has arrived.
- R8: If the stored and computed codes are equal, the status reads 0.
- R9: A single flipped data bit gives status 1 (bit 0 set only). The parity register then reads that bit's index: word in [15:4] and bit in [3:0] on a 16-bit bus, or word in [15:3] and bit in [2:0] on an 8-bit bus.
- R10: A single flipped bit within the stored code gives status 3 (bits 0 and 1).
- R11: Two flipped data bits give status 5 (bits 0 and 2).
- R12: An all-ones page read with all-ones code bytes gives status 5, and the parity register reads 0xFFFF.
- R13: Status flags keep their value across repeated reads until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| dataPhase | input | 1 | High while page data and code words are on the bus |
| dataValid | input | 1 | One-cycle strobe per bus word |
| dataIn | input | 16 | Bus word; only bits [7:0] are used on an 8-bit bus |

## Verification
The assertions assume three things about the inputs. The mode register is not rewritten while a page is in progress. A clear is not issued in the same cycle as a data strobe that should count. The host supplies exactly the configured number of words, followed by the code words. The bench changes the mode only between pages and issues each clear on its own before raising the data phase. It keeps every strobe inside the data phase, except in the one scenario that deliberately places strobes outside the phase and past the end of the page to show that they are ignored.

// File: rtl/eccPkg.sv
package eccPkg;
  localparam int DATA_W = 16;
  localparam int PAR_W  = 16;
  localparam int CNT_W  = 13;
  localparam int BASE_BYTES = 528;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_PAR  = 3'd2;
  localparam logic [2:0] REG_INV  = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

  typedef struct packed {
    logic       clear;
    logic       accum;
    logic       capture;
    logic [1:0] capIdx;
    logic       evaluate;
  } eccStrobe_t;

  function automatic logic [CNT_W-1:0] pageWords(input logic [1:0] sel, input logic wide);
    logic [CNT_W-1:0] bytes;
    bytes = CNT_W'(BASE_BYTES) << sel;
    return wide ? (bytes >> 1) : bytes;
  endfunction
endpackage

// File: rtl/eccCtrl.sv
module eccCtrl
  import eccPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic                dataPhase,
  input  logic                dataValid,
  input  logic [PAR_W-1:0]    parVal,
  input  logic [PAR_W-1:0]    invVal,
  input  logic [2:0]          flags,
  output eccStrobe_t          strobe,
  output logic                wideBus,
  output logic [CNT_W-1:0]    wordIdx
);
  logic [2:0]       modeQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] codeWords;
  logic             take;
  logic             clearNow;
  logic             lastCap;
  logic             evalPend;

  assign wideBus   = modeQ[2];
  assign limit     = pageWords(modeQ[1:0], modeQ[2]);
  assign codeWords = modeQ[2] ? CNT_W'(2) : CNT_W'(4);
  assign clearNow  = regWr && (regAddr == REG_CTRL) && regWdata[0];
  assign take      = dataPhase && dataValid && !clearNow;
  assign wordIdx   = cnt;

  always_comb begin
    strobe          = '0;
    strobe.clear    = clearNow;
    strobe.accum    = take && (cnt < limit);
    strobe.capture  = take && (cnt >= limit) && (cnt < limit + codeWords);
    strobe.capIdx   = 2'(cnt - limit);
    strobe.evaluate = evalPend;
  end

  assign lastCap = strobe.capture && (CNT_W'(strobe.capIdx) == codeWords - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      cnt      <= '0;
      evalPend <= 1'b0;
    end else begin
      if (regWr && regAddr == REG_MODE) modeQ <= regWdata[2:0];
      if (clearNow) begin
        cnt      <= '0;
        evalPend <= 1'b0;
      end else begin
        if (strobe.accum || strobe.capture) cnt <= cnt + CNT_W'(1);
        evalPend <= lastCap;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_MODE: regRdata = {29'd0, modeQ};
      REG_PAR:  regRdata = {16'd0, parVal};
      REG_INV:  regRdata = {16'd0, invVal};
      REG_STAT: regRdata = {29'd0, flags};
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  eccStrobe_t         strobe,
  input  logic               wideBus,
  input  logic [CNT_W-1:0]   wordIdx,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [PAR_W-1:0]   parVal,
  output logic [PAR_W-1:0]   invVal,
  output logic [2:0]         flags
);
  logic [PAR_W-1:0] accP;
  logic             accOdd;
  logic [PAR_W-1:0] accQ;
  logic [31:0]      storedCode;
  logic [PAR_W-1:0] synP, synQ;
  logic             checked;
  logic [3:0]       lowX;
  logic             wordOdd;
  logic [PAR_W-1:0] contrib;
  logic [PAR_W-1:0] sP, sQ;
  logic [2:0]       nextFlags;

  always_comb begin
    lowX = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if ((wideBus || b < 8) && dataIn[b]) lowX ^= 4'(b);
    end
    wordOdd = wideBus ? ^dataIn : ^dataIn[7:0];
    if (wideBus) contrib = {wordOdd ? wordIdx[11:0] : 12'd0, lowX};
    else         contrib = {wordOdd ? wordIdx : 13'd0, lowX[2:0]};
  end

  assign accQ = accP ^ {PAR_W{accOdd}};
  assign sP   = accP ^ storedCode[15:0];
  assign sQ   = accQ ^ storedCode[31:16];

  always_comb begin
    if ((sP | sQ) == '0)                nextFlags = 3'b000;
    else if ($countones({sP, sQ}) == 1) nextFlags = 3'b011;
    else if (sP == ~sQ)                 nextFlags = 3'b001;
    else                                nextFlags = 3'b101;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP <= '0; accOdd <= 1'b0; storedCode <= '0;
      synP <= '0; synQ <= '0; checked <= 1'b0; flags <= '0;
    end else if (strobe.clear) begin
      accP <= '0; accOdd <= 1'b0; storedCode <= '0;
      synP <= '0; synQ <= '0; checked <= 1'b0; flags <= '0;
    end else begin
      if (strobe.accum) begin
        accP   <= accP ^ contrib;
        accOdd <= accOdd ^ wordOdd;
      end
      if (strobe.capture) begin
        if (wideBus) storedCode[strobe.capIdx[0]*16 +: 16] <= dataIn;
        else         storedCode[strobe.capIdx*8 +: 8]      <= dataIn[7:0];
      end
      if (strobe.evaluate) begin
        synP    <= sP;
        synQ    <= sQ;
        flags   <= nextFlags;
        checked <= 1'b1;
      end
    end
  end

  assign parVal = checked ? synP : accP;
  assign invVal = checked ? synQ : accQ;
endmodule

// File: rtl/nandPageEcc.sv
module nandPageEcc
  import eccPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        dataPhase,
  input  logic        dataValid,
  input  logic [15:0] dataIn
);
  eccStrobe_t       strobe;
  logic             wideBus;
  logic [CNT_W-1:0] wordIdx;
  logic [PAR_W-1:0] parVal, invVal;
  logic [2:0]       flags;

  eccCtrl ctrl_i (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata,
    .dataPhase, .dataValid, .parVal, .invVal, .flags,
    .strobe, .wideBus, .wordIdx
  );

  eccDatapath dp_i (
    .clk, .rstN, .strobe, .wideBus, .wordIdx, .dataIn,
    .parVal, .invVal, .flags
  );
endmodule

// File: rtl/eccChk.sv
module eccChk
  import eccPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             dataPhase,
  input eccStrobe_t       strobe,
  input logic [PAR_W-1:0] parVal,
  input logic [2:0]       flags
);
  // R6
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (flags == 3'b000 && parVal == '0));

  // R13
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.evaluate) |=> $stable(flags));

  // R5
  idle_par_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataPhase && !strobe.clear && !strobe.evaluate) |=> $stable(parVal));

  // R10
  code_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[1] |-> flags[0]);

  // R11
  multi_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[2] |-> (flags[0] && !flags[1]));
endmodule

bind nandPageEcc eccChk chk_i (
  .clk(clk), .rstN(rstN), .dataPhase(dataPhase),
  .strobe(strobe), .parVal(parVal), .flags(flags)
);

// File: tb/nandPageEcc_tb_top.sv
module nandPageEcc_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        regWr = 0;
  logic [2:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic        dataPhase = 0;
  logic        dataValid = 0;
  logic [15:0] dataIn = 0;

  int total = 0;
  int bad = 0;
  logic [15:0] pg [0:4223];

  always #10 clk = ~clk;

  nandPageEcc dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0; regWdata = 0;
  endtask

  task automatic regRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic sendWord(logic [15:0] w);
    @(negedge clk); dataValid = 1; dataIn = w;
    @(negedge clk); dataValid = 0; dataIn = 16'hDEAD;
  endtask

  function automatic logic [15:0] refPar(int n, bit wide);
    logic [15:0] r = 0;
    int bw = wide ? 16 : 8;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < bw; b++)
        if (pg[w][b]) r ^= 16'(w * bw + b);
    return r;
  endfunction

  function automatic logic refOdd(int n, bit wide);
    logic o = 0;
    for (int w = 0; w < n; w++) o ^= wide ? ^pg[w] : ^pg[w][7:0];
    return o;
  endfunction

  task automatic fillPage(int n);
    for (int w = 0; w < n; w++) pg[w] = 16'(w * 37 + 5) ^ 16'(w >> 3) ^ 16'hA500;
  endtask

  task automatic runPage(int n, bit wide, bit withCode, logic [15:0] cp, logic [15:0] cq);
    regWrite(3'd0, 32'd1);
    @(negedge clk); dataPhase = 1;
    for (int w = 0; w < n; w++) sendWord(pg[w]);
    if (withCode) begin
      if (wide) begin
        sendWord(cp); sendWord(cq);
      end else begin
        sendWord({8'h00, cp[7:0]}); sendWord({8'h00, cp[15:8]});
        sendWord({8'h00, cq[7:0]}); sendWord({8'h00, cq[15:8]});
      end
    end
    @(negedge clk); dataPhase = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(3'd1, d); check("R1 mode", d, 0);
    regRead(3'd2, d); check("R1 parity", d, 0);
    regRead(3'd3, d); check("R1 inverted", d, 0);
    regRead(3'd4, d); check("R1 status", d, 0);
  endtask

  task automatic testWriteFlow();
    logic [31:0] d;
    logic [15:0] p;
    regWrite(3'd1, 32'd0);
    regRead(3'd1, d); check("R2 mode readback", d, 0);
    fillPage(528);
    runPage(528, 0, 0, 0, 0);
    p = refPar(528, 0);
    regRead(3'd2, d); check("R3 parity", d, {16'd0, p});
    regRead(3'd3, d); check("R4 inverted", d, {16'd0, p ^ {16{refOdd(528, 0)}}});
  endtask

  task automatic testChecks();
    logic [31:0] d;
    logic [15:0] p, q;
    fillPage(528);
    p = refPar(528, 0); q = p ^ {16{refOdd(528, 0)}};
    runPage(528, 0, 1, p, q);
    regRead(3'd4, d); check("R8 R7 clean status", d, 0);
    pg[100][5] = ~pg[100][5];
    runPage(528, 0, 1, p, q);
    regRead(3'd4, d); check("R9 single status", d, 1);
    regRead(3'd2, d); check("R9 single location", d, 805);
    regRead(3'd4, d); check("R13 status reread", d, 1);
    regWrite(3'd0, 32'd1);
    regRead(3'd4, d); check("R6 status cleared", d, 0);
    regRead(3'd2, d); check("R6 parity cleared", d, 0);
    pg[100][5] = ~pg[100][5];
    runPage(528, 0, 1, p, q ^ 16'h0008);
    regRead(3'd4, d); check("R10 code error", d, 3);
    pg[7][1] = ~pg[7][1]; pg[300][6] = ~pg[300][6];
    runPage(528, 0, 1, p, q);
    regRead(3'd4, d); check("R11 double error", d, 5);
  endtask

  task automatic testErased();
    logic [31:0] d;
    for (int w = 0; w < 528; w++) pg[w] = 16'hFFFF;
    runPage(528, 0, 1, 16'hFFFF, 16'hFFFF);
    regRead(3'd4, d); check("R12 erased status", d, 5);
    regRead(3'd2, d); check("R12 erased location", d, 16'hFFFF);
  endtask

  task automatic testWide();
    logic [31:0] d;
    logic [15:0] p, q;
    regWrite(3'd1, 32'd5);
    regRead(3'd1, d); check("R2 wide mode readback", d, 5);
    fillPage(528);
    p = refPar(528, 1); q = p ^ {16{refOdd(528, 1)}};
    pg[300][12] = ~pg[300][12];
    runPage(528, 1, 1, p, q);
    regRead(3'd4, d); check("R9 R7 wide single status", d, 1);
    regRead(3'd2, d); check("R9 wide location", d, 4812);
  endtask

  task automatic testBig();
    logic [31:0] d;
    logic [15:0] p, q;
    regWrite(3'd1, 32'd3);
    fillPage(4224);
    p = refPar(4224, 0); q = p ^ {16{refOdd(4224, 0)}};
    pg[4223][7] = ~pg[4223][7];
    runPage(4224, 0, 1, p, q);
    regRead(3'd4, d); check("R2 4224 page status", d, 1);
    regRead(3'd2, d); check("R2 4224 last-bit location", d, 33791);
  endtask

  task automatic testIgnore();
    logic [31:0] d;
    logic [15:0] p, q;
    regWrite(3'd1, 32'd0);
    fillPage(528);
    p = refPar(528, 0); q = p ^ {16{refOdd(528, 0)}};
    regWrite(3'd0, 32'd1);
    // R6: address-like strobes inside the phase, then a clear drops them
    @(negedge clk); dataPhase = 1;
    sendWord(16'h0033); sendWord(16'h0012);
    @(negedge clk); dataPhase = 0;
    regWrite(3'd0, 32'd1);
    // R5: strobes with the data phase low
    sendWord(16'h00F1); sendWord(16'h0077);
    regRead(3'd2, d); check("R5 idle strobes ignored", d, 0);
    @(negedge clk); dataPhase = 1;
    for (int w = 0; w < 528; w++) sendWord(pg[w]);
    sendWord({8'h00, p[7:0]}); sendWord({8'h00, p[15:8]});
    sendWord({8'h00, q[7:0]}); sendWord({8'h00, q[15:8]});
    sendWord(16'h0001); sendWord(16'h0080);
    @(negedge clk); dataPhase = 0;
    repeat (3) @(negedge clk);
    regRead(3'd4, d); check("R5 R6 status after extra strobes", d, 0);
    regRead(3'd2, d); check("R5 syndrome after extra strobes", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testWriteFlow();
    testChecks();
    testErased();
    testWide();
    testBig();
    testIgnore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule